// File: doc/BRIEF.md
# SDRAM Command Decoder and Mode Checker

This block watches the command pins of a synchronous DRAM bus from the device side. On every rising clock edge where the clock enable is high, it turns the chip-select and the three command strobes into one decoded command. It tracks which banks hold an open row, keeps the mode word, and produces a read-data enable. That enable is placed in time by the stored column latency and burst length. It can sit on a controller's bus as a protocol monitor, or stand in for a memory device's control behaviour in a larger model. No storage array is modelled.

The block rejects mode words whose burst-length, latency or operating-mode fields hold reserved codes. A rejected load leaves the stored mode unchanged, raises a fault flag and puts the model in an upset state. In that state reads and writes are not carried out and are flagged as illegal. Only a later load of a legal mode word clears the fault.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When `chipSelN` is high on a sampled edge, `cmdCode` reads 7 (no operation) after that edge, whatever the other pins are.
- R2: With `chipSelN` low, `cmdCode` after the edge equals {`rowSelN`,`colSelN`,`wrSelN`}: 0 mode load, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 burst terminate.
- R3: A mode word is legal only when all three of these hold. First, `addr[2:0]` is 0..3 (burst 1, 2, 4 or 8), or it is 7 with `addr[3]` low (full page). Second, `addr[6:4]` is 2 or 3 (column latency). Third, `addr[8:7]` is 0. A legal load replaces the stored burst length and latency and clears `modeFault`.
- R4: A legal read with latency 2 and burst 4, issued at edge k, drives `rdDataEn` high after edges k+2 through k+5 and low after edge k+6.
- R5: In general, `rdDataEn` is high after edges k+CL through k+CL+BL-1. In full-page mode it stays high until a burst terminate or a new read.
- R6: A reserved mode load sets `modeFault` after that edge and leaves the stored mode unchanged. `modeFault` then stays set through every command until a legal load.
- R7: While `modeFault` is set, a read or write gives `illegalCmd` high after the edge, and a read starts no data-enable burst.
- R8: A read or write to a bank with no open row gives `illegalCmd` high and no burst. Activate opens the selected bank. Precharge closes the selected bank, or all banks when `addr[10]` is high.
- R9: A burst terminate sampled at edge t drives `rdDataEn` low after edge t and cancels any pending burst.
- R10: A legal read issued during a burst restarts the timing from the new command, so `rdDataEn` is low until the new start edge.
- R11: An edge with `clkEn` low samples no pins: `cmdCode` shows 7, `illegalCmd` is low, and `rdDataEn`, `modeFault`, bank state and burst progress are held.
- R12: During reset, `cmdCode` is 7, `illegalCmd`, `modeFault` and `rdDataEn` are low, all banks are closed, and the mode is latency 2, burst 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable; low freezes sampling |
| chipSelN | input | 1 | Active-low chip select |
| rowSelN | input | 1 | Active-low row strobe |
| colSelN | input | 1 | Active-low column strobe |
| wrSelN | input | 1 | Active-low write strobe |
| bankSel | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address bus, also carries the mode word |
| cmdCode | output | 3 | Decoded command of the last sampled edge |
| illegalCmd | output | 1 | Last sampled read/write was illegal |
| modeFault | output | 1 | Upset state after a reserved mode load |
| rdDataEn | output | 1 | Read data window enable |

## Verification
Two functions can land on the same edge. One case is a burst terminate or a new read arriving while a burst is still under way: the new command must shorten or restart the window. The other is a clock-enable low cycle falling inside the latency delay or the data window, which must freeze the burst where it stands. The bench sets up both on purpose: a read, then a terminate or second read a few cycles later, and clock-enable pulses during full-page and eight-beat bursts. A long random phase then mixes all commands. A behavioural model counts only enabled edges and keeps a start/end window, and it judges every cycle against the outputs.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'd0,
    CMD_REF = 3'd1,
    CMD_PRE = 3'd2,
    CMD_ACT = 3'd3,
    CMD_WR  = 3'd4,
    CMD_RD  = 3'd5,
    CMD_BST = 3'd6,
    CMD_NOP = 3'd7
  } cmdE;

  // strobes from control to datapath, already gated by the clock enable
  typedef struct packed {
    logic loadMode;
    logic rdStart;
    logic burstStop;
  } strobeS;

  // mode word fields: [2:0] burst code, [3] burst order, [6:4] latency, [8:7] op
  function automatic logic modeLegal(input logic [8:0] w);
    logic blOk, clOk, opOk;
    blOk = (w[2:0] <= 3'd3) || (w[2:0] == 3'd7 && !w[3]);
    clOk = (w[6:4] == 3'd2) || (w[6:4] == 3'd3);
    opOk = (w[8:7] == 2'd0);
    return blOk && clOk && opOk;
  endfunction

endpackage

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              chipSelN,
  input  logic              rowSelN,
  input  logic              colSelN,
  input  logic              wrSelN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [8:0]        modeWord,
  input  logic              allBanks,
  output strobeS            strobe,
  output logic [2:0]        cmdCode,
  output logic              illegalCmd,
  output logic              modeFault
);

  cmdE  pinCmd;
  logic modeOk;
  logic bankHit;
  logic isRdWr;
  logic bankOpen [NUM_BANKS];

  always_comb begin
    pinCmd  = chipSelN ? CMD_NOP : cmdE'({rowSelN, colSelN, wrSelN});
    modeOk  = modeLegal(modeWord);
    bankHit = bankOpen[bankSel];
    isRdWr  = (pinCmd == CMD_RD) || (pinCmd == CMD_WR);
    strobe.loadMode  = clkEn && (pinCmd == CMD_LMR) && modeOk;
    strobe.rdStart   = clkEn && (pinCmd == CMD_RD) && bankHit && !modeFault;
    strobe.burstStop = clkEn && (pinCmd == CMD_BST);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
      end else if (clkEn) begin
        if (pinCmd == CMD_ACT && bankSel == BANK_W'(b))
          bankOpen[b] <= 1'b1;
        else if (pinCmd == CMD_PRE && (allBanks || bankSel == BANK_W'(b)))
          bankOpen[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode    <= CMD_NOP;
      illegalCmd <= 1'b0;
      modeFault  <= 1'b0;
    end else if (!clkEn) begin
      cmdCode    <= CMD_NOP;
      illegalCmd <= 1'b0;
    end else begin
      cmdCode    <= pinCmd;
      illegalCmd <= isRdWr && (modeFault || !bankHit);
      if (pinCmd == CMD_LMR)
        modeFault <= !modeOk;
    end
  end

  AST_CS_HIGH_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && chipSelN) |=> (cmdCode == CMD_NOP)); // R1
  AST_FREEZE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> (cmdCode == CMD_NOP && !illegalCmd)); // R11
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modeFault && !strobe.loadMode) |=> modeFault); // R6
  AST_FAULT_RDWR_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && modeFault && isRdWr) |=> illegalCmd); // R7
  AST_FAULT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> !strobe.rdStart); // R7

endmodule

// File: rtl/sdram_mon_dp.sv
module sdram_mon_dp
  import sdram_mon_pkg::*;
#(
  parameter int MAX_BL = 8,
  localparam int CNT_W = $clog2(MAX_BL + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  strobeS     strobe,
  input  logic [2:0] blField,
  input  logic [2:0] clField,
  output logic       rdDataEn
);

  logic [2:0]       blCode;
  logic [2:0]       clCode;
  logic [1:0]       dly;
  logic [CNT_W-1:0] rem;
  logic             fullPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blCode   <= 3'd0;
      clCode   <= 3'd2;
      dly      <= 2'd0;
      rem      <= '0;
      fullPage <= 1'b0;
      rdDataEn <= 1'b0;
    end else if (clkEn) begin
      if (strobe.loadMode) begin
        blCode <= blField;
        clCode <= clField;
      end
      if (strobe.rdStart) begin
        dly      <= clCode[1:0] - 2'd1;
        rem      <= (blCode == 3'd7) ? '0 : (CNT_W'(1) << blCode[1:0]);
        fullPage <= (blCode == 3'd7);
        rdDataEn <= 1'b0;
      end else if (strobe.burstStop) begin
        dly      <= 2'd0;
        rem      <= '0;
        fullPage <= 1'b0;
        rdDataEn <= 1'b0;
      end else if (dly != 2'd0) begin
        dly      <= dly - 2'd1;
      end else if (fullPage || rem != '0) begin
        rdDataEn <= 1'b1;
        if (!fullPage) rem <= rem - CNT_W'(1);
      end else begin
        rdDataEn <= 1'b0;
      end
    end
  end

  AST_LATENCY_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (clCode == 3'd2 || clCode == 3'd3)); // R3
  AST_BURST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (blCode <= 3'd3 || blCode == 3'd7)); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.burstStop |=> !rdDataEn); // R9
  AST_START_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStart |=> !rdDataEn); // R10
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(rdDataEn)); // R11

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int MAX_BL    = 8,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              chipSelN,
  input  logic              rowSelN,
  input  logic              colSelN,
  input  logic              wrSelN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        cmdCode,
  output logic              illegalCmd,
  output logic              modeFault,
  output logic              rdDataEn
);

  strobeS strobe;
  logic   unusedAddr;

  assign unusedAddr = ^addr;

  sdram_mon_ctrl #(.NUM_BANKS(NUM_BANKS), .AP_BIT(AP_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .chipSelN(chipSelN), .rowSelN(rowSelN), .colSelN(colSelN), .wrSelN(wrSelN),
    .bankSel(bankSel), .modeWord(addr[8:0]), .allBanks(addr[AP_BIT]),
    .strobe(strobe), .cmdCode(cmdCode), .illegalCmd(illegalCmd),
    .modeFault(modeFault)
  );

  sdram_mon_dp #(.MAX_BL(MAX_BL)) i_dp (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .strobe(strobe),
    .blField(addr[2:0]), .clField(addr[6:4]), .rdDataEn(rdDataEn)
  );

endmodule

// File: tb/test_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdram_cmd_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1, chipSelN = 1'b1, rowSelN = 1'b1, colSelN = 1'b1, wrSelN = 1'b1;
  logic [1:0]  bankSel = '0;
  logic [11:0] addr = '0;
  logic [2:0]  cmdCode;
  logic        illegalCmd, modeFault, rdDataEn;

  int checks = 0, errors = 0;
  bit cmpOn = 1'b0;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSelN(chipSelN), .rowSelN(rowSelN),
    .colSelN(colSelN), .wrSelN(wrSelN), .bankSel(bankSel), .addr(addr),
    .cmdCode(cmdCode), .illegalCmd(illegalCmd), .modeFault(modeFault), .rdDataEn(rdDataEn)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int  mCl = 2, mBl = 0;
  bit  mFault = 0;
  bit  mOpen [4];
  int  edgeN = 0, startE = 0, endE = 0;
  int  expCmd = 7;
  bit  expIll = 0, expEn = 0;

  function automatic bit legalWord(int w);
    int bl, bt, cl, op;
    bl = w & 7; bt = (w >> 3) & 1; cl = (w >> 4) & 7; op = (w >> 7) & 3;
    return ((bl <= 3) || (bl == 7 && bt == 0)) && (cl == 2 || cl == 3) && (op == 0);
  endfunction

  always @(posedge clk) begin
    int c;
    bit hit;
    if (!rstN) begin
      mCl = 2; mBl = 0; mFault = 0;
      foreach (mOpen[i]) mOpen[i] = 0;
      edgeN = 0; startE = 0; endE = 0;
      expCmd = 7; expIll = 0; expEn = 0;
    end else if (!clkEn) begin
      expCmd = 7; expIll = 0;
    end else begin
      c = chipSelN ? 7 : int'({rowSelN, colSelN, wrSelN});
      edgeN++;
      hit = mOpen[bankSel];
      expCmd = c;
      expIll = (c == 4 || c == 5) && (mFault || !hit);
      case (c)
        0: if (legalWord(int'(addr))) begin
             mBl = addr & 7; mCl = (addr >> 4) & 7; mFault = 0;
           end else mFault = 1;
        2: if (addr[10]) foreach (mOpen[i]) mOpen[i] = 0;
           else mOpen[bankSel] = 0;
        3: mOpen[bankSel] = 1;
        5: if (hit && !mFault) begin
             startE = edgeN + mCl;
             endE = (mBl == 7) ? 32'h7fffffff : startE + (1 << mBl);
           end
        6: if (endE > edgeN) endE = edgeN;
        default: ;
      endcase
      expEn = (edgeN >= startE) && (edgeN < endE);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    check(cmdCode == expCmd, "R1/R2/R11 cmdCode", cmdCode, expCmd);
    check(illegalCmd == expIll, "R7/R8/R11 illegalCmd", illegalCmd, expIll);
    check(modeFault == mFault, "R3/R6 modeFault", modeFault, mFault);
    check(rdDataEn == expEn, "R4/R5/R9/R10/R11 rdDataEn", rdDataEn, expEn);
  end

  // ---------------- stimulus ----------------
  function automatic int mw(int cl, int bl, int bt = 0, int op = 0);
    return bl | (bt << 3) | (cl << 4) | (op << 7);
  endfunction

  task automatic issue(int c, int b, int a);
    @(negedge clk);
    clkEn = 1'b1; chipSelN = 1'b0;
    {rowSelN, colSelN, wrSelN} = 3'(c);
    bankSel = 2'(b); addr = 12'(a);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      clkEn = 1'b1; chipSelN = 1'b1;
      {rowSelN, colSelN, wrSelN} = 3'($urandom);
      addr = 12'($urandom);
    end
  endtask

  task automatic freeze(int n);
    repeat (n) begin
      @(negedge clk);
      clkEn = 1'b0; chipSelN = 1'b0;
      {rowSelN, colSelN, wrSelN} = 3'd5;
      addr = 12'($urandom);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cmpOn = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(cmdCode == 3'd7 && !illegalCmd && !modeFault && !rdDataEn,
          "R12 reset state", {cmdCode, illegalCmd, modeFault, rdDataEn}, 56);
    rstN = 1'b1;
    idle(2);
    // R4: latency 2, burst 4
    issue(0, 0, mw(2, 2));
    issue(3, 0, 0);
    issue(5, 0, 0);
    idle(8);
    // R8: closed bank read and write
    issue(5, 1, 0); issue(4, 2, 0); idle(3);
    // R5: latency 3, burst 8, terminate mid-burst (R9)
    issue(0, 0, mw(3, 3));
    issue(5, 0, 0); idle(5);
    issue(6, 0, 0); idle(4);
    // R10: restart during burst
    issue(5, 0, 0); idle(4); issue(5, 0, 0); idle(12);
    // terminate during latency delay
    issue(5, 0, 0); issue(6, 0, 0); idle(6);
    // R5: burst 1 and 2
    issue(0, 0, mw(2, 0)); issue(5, 0, 0); idle(4);
    issue(0, 0, mw(3, 1)); issue(5, 0, 0); idle(5);
    // R11: clock enable low inside a burst
    issue(0, 0, mw(2, 3)); issue(5, 0, 0); idle(3); freeze(3); idle(2); freeze(2); idle(8);
    // R8: precharge single and all
    issue(3, 1, 0); issue(2, 0, 0); issue(5, 0, 0); issue(5, 1, 0);
    issue(2, 3, 12'h400); issue(4, 1, 0); idle(2);
    // R6/R7: reserved loads
    issue(3, 2, 0);
    issue(0, 0, mw(4, 2)); issue(5, 2, 0); issue(4, 2, 0); idle(6);
    issue(0, 0, mw(2, 2, 0, 1)); issue(5, 2, 0); idle(3);
    issue(0, 0, mw(2, 7, 1)); issue(1, 0, 0); issue(3, 1, 0); issue(5, 2, 0); idle(3);
    issue(0, 0, mw(2, 5)); idle(2);
    // R3: legal full page clears fault
    issue(0, 0, mw(2, 7)); issue(5, 2, 0); idle(20);
    freeze(4); idle(5); issue(6, 0, 0); idle(4);
    // R1: chip select high with random pins
    idle(20);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 8) freeze(1 + $urandom % 3);
      else if (r < 20) idle(1 + $urandom % 4);
      else if (r < 26) begin
        if ($urandom % 8 == 0) issue(0, 0, int'($urandom % 4096));
        else issue(0, 0, mw(2 + $urandom % 2, ($urandom % 5 == 0) ? 7 : $urandom % 4));
      end
      else if (r < 44) issue(3, $urandom % 4, 0);
      else if (r < 52) issue(2, $urandom % 4, ($urandom % 4 == 0) ? 12'h400 : 0);
      else if (r < 78) issue(5, $urandom % 4, 0);
      else if (r < 88) issue(4, $urandom % 4, 0);
      else if (r < 95) issue(6, 0, 0);
      else issue(1, 0, 0);
    end
    idle(12);
    summary();
    $finish;
  end

endmodule